// File: doc/BRIEF.md
# Byte-Serial Link Port Controller

This block is a two-register serial link port for a small handheld system. A CPU reads and writes it over a plain single-cycle bus. One register holds the byte being exchanged. The other selects the bit clock source and the bit rate, and carries a busy flag that starts a transfer. During a transfer the data register is itself the shift register. One bit leaves at its top end while the partner's bit enters at the bottom, so after eight bit times the register holds the partner's byte and the partner holds ours.

When the internal clock source is selected, the port is the master. It makes the bit clock from the system clock with a prescaler, which has one divide ratio for the normal rate and another for the fast rate, and it drives that clock onto the link. When the external source is selected, the port is the slave. It follows the partner's clock, which arrives through a synchroniser. A slave exchanges a byte whenever the partner clocks it, whether or not software has armed it. Each completed byte raises a one-cycle interrupt request.

Top module: `link_port_ctrl`

## Requirements
- R1: After reset the data register reads 0x00, the control register reads 0x7C, serial-out and clock-out are 1, and the interrupt request is 0.
- R2: The control register reads {busy, 1,1,1,1,1, fast, internal}. Busy is bit 7, fast rate is bit 1 and internal clock is bit 0. Writes to bits 6..2 have no effect. For example, writing 0x02 reads back 0x7E and writing 0x03 reads back 0x7F.
- R3: Writing the control register with bit 7 = 1 and bit 0 = 1 starts a master exchange. The data register goes out most significant bit first on serial-out, serial-in is captured into bit 0, and afterwards the data register holds the received byte.
- R4: Clock-out rests at 1 whenever no master transfer runs. A master transfer makes exactly eight low pulses, and the clock spends NORM_HALF cycles low per bit at normal rate and FAST_HALF cycles low per bit at fast rate.
- R5: At the end of the eighth bit, bit 7 of the control register clears, so it reads 0x7D after 0x81 was written. The interrupt request is high for exactly one cycle.
- R6: A master exchange with serial-in held at 1 (no partner) receives 0xFF.
- R7: After a transfer, serial-out keeps the last bit shifted out, which is bit 0 of the byte sent.
- R8: With bit 0 = 0 (slave), eight partner clock cycles on clock-in exchange a byte. Serial-out changes after a falling edge and serial-in is sampled at a rising edge. This happens whether or not bit 7 was set. The interrupt request pulses once, and bit 7 reads 0 afterwards.
- R9: CPU writes to the data register while a transfer is in progress are ignored.
- R10: Writing bit 7 from 0 to 1 restarts the bit count, so a partly clocked slave byte is abandoned and a full eight further clocks are needed before the interrupt.
- R11: In slave mode clock-out never goes low. In master mode edges on clock-in have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_sel | input | 1 | Register select: 0 data, 1 control |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register |
| ser_in | input | 1 | Serial data from partner (idle high) |
| clk_in | input | 1 | Partner bit clock (idle high) |
| ser_out | output | 1 | Serial data to partner |
| clk_out | output | 1 | Bit clock to partner, high at rest |
| clk_out_en | output | 1 | High when clock-out should drive the cable (internal source) |
| irq | output | 1 | One-cycle transfer-complete request |

## Verification
The bench builds the port with NORM_HALF = 10 and FAST_HALF = 6 in place of the long default division. A full master byte then takes under two hundred cycles, which lets both bit rates be measured low-cycle by low-cycle against the parameters. With half periods this short, the two-flop synchroniser delay is a large fraction of a bit. A partner model that reacts to the port's own clock must therefore still meet the sample point, which tests the ordering of output change and input sample. The slave tests drive the partner clock slowly enough for the synchroniser, and they include a byte that is abandoned part-way.

// File: rtl/link_port_pkg.sv
// Shared definitions for the link port: control bit positions,
// the control state record and its read-back view.
package link_port_pkg;
    localparam int BYTE_W = 8;
    localparam int CTL_BUSY_BIT = 7;
    localparam int CTL_FAST_BIT = 1;
    localparam int CTL_SRC_BIT = 0;

    typedef struct packed {
        logic busy;
        logic fast;
        logic internal;
    } lp_ctrl_t;

    // Read-back value of the control register; unimplemented bits read 1.
    function automatic logic [BYTE_W-1:0] ctrl_view(lp_ctrl_t c);
        return {c.busy, 5'b11111, c.fast, c.internal};
    endfunction
endpackage

// File: rtl/lp_sync_edge.sv
// Multi-stage synchroniser for asynchronous link inputs, with edge
// detection on one selected bit. Assumes idle-high lines, so every stage
// resets to 1 and no false edge appears after reset.
module lp_sync_edge #(
    parameter int W        = 2,
    parameter int STAGES   = 2,
    parameter int EDGE_IDX = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out,
    output logic         edge_rise,
    output logic         edge_fall
);
    logic [STAGES-1:0][W-1:0] pipe;
    logic                     prev;

    // Shift the raw inputs through the synchroniser stages.
    always_ff @(posedge clk) begin
        if (!rst_n) pipe <= '1;
        else        pipe <= {pipe[STAGES-2:0], async_in};
    end

    assign sync_out = pipe[STAGES-1];

    // Remember the previous synchronised level of the edge-detected bit.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b1;
        else        prev <= sync_out[EDGE_IDX];
    end

    assign edge_rise =  sync_out[EDGE_IDX] & ~prev;
    assign edge_fall = ~sync_out[EDGE_IDX] &  prev;
endmodule

// File: rtl/lp_bit_clock.sv
// Master bit-clock generator. While run is high it produces a low half
// and a high half per bit, each lasting the selected half-period count,
// and signals the falling and rising edges one cycle before clk_out shows
// them. It assumes run drops right after the last rising edge.
module lp_bit_clock #(
    parameter int NORM_HALF = 256,
    parameter int FAST_HALF = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic fast,
    output logic fall_tick,
    output logic rise_tick,
    output logic clk_out
);
    localparam int MAX_HALF = (NORM_HALF > FAST_HALF) ? NORM_HALF : FAST_HALF;
    localparam int CW       = $clog2(MAX_HALF) + 1;

    logic [CW-1:0] cnt;
    logic [CW-1:0] limit;
    logic          low_q;
    logic          first_q;
    logic          wrap;

    assign limit = fast ? CW'(FAST_HALF - 1) : CW'(NORM_HALF - 1);
    assign wrap  = (cnt >= limit);

    // Edge strobes: first falling edge immediately, later ones at half-period ends.
    always_comb begin
        fall_tick = run & (first_q | (~low_q & wrap));
        rise_tick = run & ~first_q & low_q & wrap;
    end

    // Half-period counter and clock level.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt     <= '0;
            low_q   <= 1'b0;
            first_q <= 1'b1;
        end else if (first_q) begin
            cnt     <= '0;
            low_q   <= 1'b1;
            first_q <= 1'b0;
        end else if (wrap) begin
            cnt     <= '0;
            low_q   <= ~low_q;
        end else begin
            cnt     <= cnt + 1'b1;
        end
    end

    assign clk_out = ~low_q;
endmodule

// File: rtl/lp_shift_core.sv
// Data register that doubles as the shift register. A shift moves the
// register left one place and takes the serial input into bit 0. An
// output strobe copies the top bit to the serial output, which then
// holds. It counts shifts and flags the last one of a byte.
module lp_shift_core #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_en,
    input  logic [W-1:0] load_data,
    input  logic         shift_tick,
    input  logic         out_tick,
    input  logic         ser_in,
    input  logic         cnt_clear,
    output logic [W-1:0] data_q,
    output logic         ser_out,
    output logic         active,
    output logic         done
);
    localparam int CNT_W = $clog2(W);

    logic [CNT_W-1:0] bit_cnt;

    assign done   = shift_tick && (bit_cnt == CNT_W'(W - 1));
    assign active = (bit_cnt != '0);

    // Parallel load from the CPU, or shift one bit on a sample strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)          data_q <= '0;
        else if (load_en)    data_q <= load_data;
        else if (shift_tick) data_q <= {data_q[W-2:0], ser_in};
    end

    // Count sampled bits; wrap at a full byte, restart on request.
    always_ff @(posedge clk) begin
        if (!rst_n || cnt_clear) bit_cnt <= '0;
        else if (shift_tick)     bit_cnt <= done ? '0 : bit_cnt + 1'b1;
    end

    // Present the outgoing bit and hold it between strobes.
    always_ff @(posedge clk) begin
        if (!rst_n)        ser_out <= 1'b1;
        else if (out_tick) ser_out <= data_q[W-1];
    end
endmodule

// File: rtl/link_port_ctrl.sv
// Byte-serial link port top level. It holds the control register,
// chooses master or slave edge strobes, blocks data writes while busy
// and registers the completion interrupt. It assumes the CPU bus writes
// for one cycle and reads combinationally.
module link_port_ctrl
    import link_port_pkg::*;
#(
    parameter int NORM_HALF   = 256,
    parameter int FAST_HALF   = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_sel,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              ser_in,
    input  logic              clk_in,
    output logic              ser_out,
    output logic              clk_out,
    output logic              clk_out_en,
    output logic              irq
);
    lp_ctrl_t          ctrl_q;
    logic [1:0]        line_sync;
    logic              ext_rise, ext_fall;
    logic              m_fall, m_rise;
    logic              shift_tick, out_tick;
    logic              mst_run, busy, active, done;
    logic [BYTE_W-1:0] data_q;
    logic              wr_ctrl, wr_data, cnt_clear;

    assign wr_ctrl   = bus_wr &  bus_sel;
    assign wr_data   = bus_wr & ~bus_sel;
    assign mst_run   = ctrl_q.busy & ctrl_q.internal;
    assign busy      = mst_run | active;
    assign cnt_clear = wr_ctrl & bus_wdata[CTL_BUSY_BIT] & ~ctrl_q.busy;

    lp_sync_edge #(.W(2), .STAGES(SYNC_STAGES), .EDGE_IDX(1)) sync_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .async_in  ({clk_in, ser_in}),
        .sync_out  (line_sync),
        .edge_rise (ext_rise),
        .edge_fall (ext_fall)
    );

    lp_bit_clock #(.NORM_HALF(NORM_HALF), .FAST_HALF(FAST_HALF)) bclk_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (mst_run),
        .fast      (ctrl_q.fast),
        .fall_tick (m_fall),
        .rise_tick (m_rise),
        .clk_out   (clk_out)
    );

    // Pick the edge strobes of the selected clock source.
    always_comb begin
        if (ctrl_q.internal) begin
            shift_tick = m_rise;
            out_tick   = m_fall;
        end else begin
            shift_tick = ext_rise;
            out_tick   = ext_fall;
        end
    end

    lp_shift_core #(.W(BYTE_W)) shift_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_en    (wr_data & ~busy),
        .load_data  (bus_wdata),
        .shift_tick (shift_tick),
        .out_tick   (out_tick),
        .ser_in     (line_sync[0]),
        .cnt_clear  (cnt_clear),
        .data_q     (data_q),
        .ser_out    (ser_out),
        .active     (active),
        .done       (done)
    );

    // Control register: CPU writes, busy cleared when a byte completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl_q.fast     <= bus_wdata[CTL_FAST_BIT];
                ctrl_q.internal <= bus_wdata[CTL_SRC_BIT];
            end
            if (done)         ctrl_q.busy <= 1'b0;
            else if (wr_ctrl) ctrl_q.busy <= bus_wdata[CTL_BUSY_BIT];
        end
    end

    // One-cycle completion request.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= done;
    end

    assign clk_out_en = ctrl_q.internal;
    assign bus_rdata  = bus_sel ? ctrl_view(ctrl_q) : data_q;
endmodule

// File: rtl/lp_checker.sv
// Temporal checks on the link port, attached to every instance by bind.
module lp_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       irq,
    input logic       clk_out,
    input logic       ser_out,
    input logic       internal,
    input logic       busy_flag,
    input logic       out_tick,
    input logic       shift_tick,
    input logic       busy,
    input logic [7:0] data_q,
    input logic       bus_sel,
    input logic [7:0] bus_rdata
);
    // R5
    irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R5
    busy_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !busy_flag);

    // R11
    clk_master_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_out |-> internal);

    // R7
    sout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_tick |=> $stable(ser_out));

    // R9
    data_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !shift_tick) |=> $stable(data_q));

    // R2
    unused_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_sel |-> (bus_rdata[6:2] == 5'b11111));
endmodule

bind link_port_ctrl lp_checker chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq        (irq),
    .clk_out    (clk_out),
    .ser_out    (ser_out),
    .internal   (ctrl_q.internal),
    .busy_flag  (ctrl_q.busy),
    .out_tick   (out_tick),
    .shift_tick (shift_tick),
    .busy       (busy),
    .data_q     (data_q),
    .bus_sel    (bus_sel),
    .bus_rdata  (bus_rdata)
);

// File: tb/link_port_ctrl_tb_top.sv
module link_port_ctrl_tb_top;
    localparam int NH = 10;
    localparam int FH = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_sel = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       ser_out, clk_out, clk_out_en, irq;
    logic       sin_lvl = 1'b1, cin_lvl = 1'b1;
    logic       p_en = 1'b0, p_load = 1'b0, p_sin = 1'b1;
    logic [7:0] p_init = 8'h00, p_byte = 8'h00;
    logic       cout_prev = 1'b1, irq_prev = 1'b0;
    int         falls = 0, low_cyc = 0, irq_cnt = 0, irq_dbl = 0;
    int         vectors = 0, miscompares = 0;

    always #10 clk = ~clk;

    link_port_ctrl #(.NORM_HALF(NH), .FAST_HALF(FH)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_sel(bus_sel),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ser_in(p_en ? p_sin : sin_lvl), .clk_in(cin_lvl),
        .ser_out(ser_out), .clk_out(clk_out), .clk_out_en(clk_out_en), .irq(irq)
    );

    // Monitor and partner model reacting to the port's own clock.
    always @(posedge clk) begin
        cout_prev <= clk_out;
        irq_prev  <= irq;
        if (cout_prev && !clk_out) begin
            falls <= falls + 1;
            if (p_en) p_sin <= p_byte[7];
        end
        if (!cout_prev && clk_out && p_en) p_byte <= {p_byte[6:0], ser_out};
        else if (p_load) p_byte <= p_init;
        if (!clk_out) low_cyc <= low_cyc + 1;
        if (irq) irq_cnt <= irq_cnt + 1;
        if (irq && irq_prev) irq_dbl <= irq_dbl + 1;
    end

    task automatic check(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        @(negedge clk);
        bus_sel = sel; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic sel, output logic [7:0] d);
        @(negedge clk);
        bus_sel = sel;
        #1 d = bus_rdata;
    endtask

    task automatic wait_irq(input int base);
        for (int i = 0; i < 3000 && irq_cnt == base; i++) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic slave_bit(input logic b, output logic o);
        cin_lvl = 1'b0; sin_lvl = b;
        repeat (6) @(negedge clk);
        o = ser_out;
        cin_lvl = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd(1'b0, v); check("R1 data", v, 8'h00);
        rd(1'b1, v); check("R1 ctrl", v, 8'h7C);
        check("R1 sout", ser_out, 1); check("R1 cout", clk_out, 1);
        check("R1 irq", irq, 0);
    endtask

    task automatic t_ctrl_bits();
        logic [7:0] v;
        wr(1'b1, 8'h02); rd(1'b1, v); check("R2 fast", v, 8'h7E);
        wr(1'b1, 8'h03); rd(1'b1, v); check("R2 both", v, 8'h7F);
        wr(1'b1, 8'h7C); rd(1'b1, v); check("R2 unused", v, 8'h7C);
        check("R4 idle cout", clk_out, 1);
    endtask

    task automatic t_master(input logic [7:0] d, input logic [7:0] pb,
                            input logic fast, input logic midwr);
        logic [7:0] v;
        int f0, l0, i0, h;
        h = fast ? FH : NH;
        wr(1'b0, d);
        @(negedge clk); p_init = pb; p_load = 1'b1; p_en = 1'b1;
        @(negedge clk); p_load = 1'b0;
        f0 = falls; l0 = low_cyc; i0 = irq_cnt;
        wr(1'b1, fast ? 8'h83 : 8'h81);
        if (midwr) begin
            repeat (50) @(negedge clk);
            wr(1'b0, 8'h00);
        end
        wait_irq(i0);
        rd(1'b0, v);
        check(midwr ? "R9 rx kept" : "R3 rx", v, pb);
        check(midwr ? "R9 tx kept" : "R3 tx", p_byte, d);
        check("R4 pulses", falls - f0, 8);
        check("R4 low cycles", low_cyc - l0, 8 * h);
        rd(1'b1, v); check("R5 ctrl", v, fast ? 8'h7F : 8'h7D);
        check("R5 irq once", irq_cnt - i0, 1);
        check("R5 irq width", irq_dbl, 0);
        check("R7 sout hold", ser_out, d[0]);
        p_en = 1'b0;
    endtask

    task automatic t_no_partner();
        logic [7:0] v;
        int f0, i0;
        sin_lvl = 1'b1;
        wr(1'b0, 8'h5A);
        f0 = falls; i0 = irq_cnt;
        fork
            begin
                for (int k = 0; k < 30; k++) begin
                    cin_lvl = ~cin_lvl;
                    repeat (3) @(negedge clk);
                end
                cin_lvl = 1'b1;
            end
            begin
                wr(1'b1, 8'h83);
                wait_irq(i0);
            end
        join
        repeat (8) @(negedge clk);
        rd(1'b0, v); check("R6 rx ff", v, 8'hFF);
        check("R11 clkin ignored pulses", falls - f0, 8);
        check("R11 clkin ignored irq", irq_cnt - i0, 1);
        check("R7 sout last", ser_out, 0);
    endtask

    task automatic t_slave(input logic [7:0] d, input logic [7:0] pb, input logic arm);
        logic [7:0] v, sent;
        logic o;
        int f0, i0;
        wr(1'b1, arm ? 8'h80 : 8'h00);
        wr(1'b0, d);
        f0 = falls; i0 = irq_cnt;
        for (int k = 7; k >= 0; k--) begin
            slave_bit(pb[k], o);
            sent[k] = o;
        end
        rd(1'b0, v); check("R8 rx", v, pb);
        check("R8 tx", sent, d);
        check("R8 irq", irq_cnt - i0, 1);
        rd(1'b1, v); check("R8 busy cleared", v, 8'h7C);
        check("R11 no cout", falls - f0, 0);
        check("R7 slave sout", ser_out, d[0]);
    endtask

    task automatic t_restart();
        logic [7:0] v;
        logic o;
        int i0;
        wr(1'b1, 8'h00);
        wr(1'b0, 8'h00);
        i0 = irq_cnt;
        for (int k = 0; k < 3; k++) slave_bit(1'b1, o);
        wr(1'b0, 8'h44);
        rd(1'b0, v); check("R9 slave write ignored", v, 8'h07);
        wr(1'b1, 8'h80);
        for (int k = 7; k >= 3; k--) slave_bit(k[0], o);
        check("R10 no early irq", irq_cnt - i0, 0);
        for (int k = 2; k >= 0; k--) slave_bit(k[0], o);
        check("R10 irq after full byte", irq_cnt - i0, 1);
        rd(1'b0, v); check("R10 rx", v, 8'hAA);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_ctrl_bits();
        t_master(8'hA5, 8'h3C, 1'b0, 1'b0);
        t_master(8'h68, 8'hC3, 1'b1, 1'b0);
        t_master(8'hA5, 8'h3C, 1'b0, 1'b1);
        t_no_partner();
        t_slave(8'h75, 8'h9E, 1'b0);
        t_slave(8'h2C, 8'h81, 1'b1);
        t_restart();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule